// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block sits between a transaction queue and a low-level I2C bit engine. It takes message descriptors one at a time and turns each one into the bus commands and address bytes needed before the data phase: the opening START, an optional high-speed entry, 7-bit or 10-bit address bytes, repeated STARTs between messages, and the closing STOP. Every byte it writes is judged by the engine's ACK/NAK answer. Any failure aborts the transaction with a STOP.

The data phase of each message is not moved by this block. It is handed to a separate data mover through a start/done pulse pair. A descriptor carries a 10-bit address, a ten-bit flag, a read flag, a no-start flag, a last-message flag and a high-speed request. The high-speed request is only taken from the first descriptor of a transaction. A watchdog bounds every step that waits on the engine or the data mover. When a transaction ends, a one-cycle done pulse reports success or one of three error kinds.

Top module: `i2c_addr_seq`

## Requirements
- R1: For a 7-bit message, one WRITE carries the byte {addr[6:0], rd}, with bit 0 set to 1 for a read.
- R2: For a 10-bit message, the first WRITE carries {5'b11110, addr[9:8], 1'b0} and the second carries addr[7:0].
- R3: For a 10-bit read, the two header bytes are followed by a RESTART and then a WRITE of {5'b11110, addr[9:8], 1'b1}.
- R4: A transaction opens with START, and the no-start flag is ignored on its first message. Each later message gets a RESTART and its address bytes. A later message whose no-start flag is set gets neither and goes straight to its data phase.
- R5: A NAK on any address byte ends the transaction with STOP and result 1. No data phase follows.
- R6: When the high-speed request is set, the WRITE of master code 0x08 follows START at standard speed, with speed_hs low. The master code must be NAKed. After that NAK, speed_hs goes high and a RESTART precedes the first address byte. An ACK of the master code gives STOP and result 1.
- R7: Every transaction ends with exactly one STOP. txn_done is a one-cycle pulse after the STOP completes, with txn_result valid in that cycle: 0 success, 1 NAK, 2 data failure, 3 timeout. speed_hs stays high through the STOP command and is low in the txn_done cycle.
- R8: After its address phase, each message raises xfer_start once and waits for xfer_done. xfer_ok low at xfer_done gives STOP and result 2. Success of the last message gives STOP and result 0.
- R9: A step whose completion comes in the TIMEOUT_CYC-th cycle after issue is accepted. A step with no completion by then is aborted, and the transaction ends with STOP and result 3.
- R10: Commands are encoded on cmd_op as 0 START, 1 RESTART, 2 STOP and 3 WRITE (with cmd_byte). cmd_valid is a one-cycle pulse, and at most one command or data step is outstanding.
- R11: After reset, desc_ready is high and cmd_valid, xfer_start, txn_done and speed_hs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer accepts a descriptor this cycle |
| desc_addr | input | 10 | Target address (7-bit uses bits 6:0) |
| desc_ten | input | 1 | 10-bit addressing |
| desc_rd | input | 1 | Read message |
| desc_nostart | input | 1 | Continue the previous message without RESTART or address |
| desc_last | input | 1 | Final message of the transaction |
| desc_hs | input | 1 | Enter high speed (first descriptor only) |
| cmd_valid | output | 1 | Command pulse to the bit engine |
| cmd_op | output | 2 | 0 START, 1 RESTART, 2 STOP, 3 WRITE |
| cmd_byte | output | 8 | Byte for WRITE |
| cmd_done | input | 1 | Engine finished the outstanding command |
| cmd_nak | input | 1 | With cmd_done: the byte was NAKed |
| xfer_start | output | 1 | Start data phase of current message |
| xfer_done | input | 1 | Data phase finished |
| xfer_ok | input | 1 | With xfer_done: data phase succeeded |
| speed_hs | output | 1 | High-speed timing select |
| txn_done | output | 1 | Transaction finished (one cycle) |
| txn_result | output | 2 | Result code, valid with txn_done |

## Verification
A step's completion and the watchdog's expiry can land in the same cycle. The completion must win. This case is provoked by making the engine answer every command exactly TIMEOUT_CYC cycles after it was issued. The transaction must then still end with success and the full command order. A separate case leaves a START or a data phase unanswered. That must produce a STOP and result 3, and it shows that expiry in a cycle with no completion is not swallowed.

// File: rtl/i2c_aseq_pkg.sv
package i2c_aseq_pkg;
    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] MASTER_CODE = 8'h08;

    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_RESTART = 2'd1,
        OP_STOP    = 2'd2,
        OP_WRITE   = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NAK     = 2'd1,
        RES_DATA    = 2'd2,
        RES_TIMEOUT = 2'd3
    } res_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_MCODE, ST_HSRS, ST_RS, ST_A1, ST_A2,
        ST_RRS, ST_A3, ST_DATA, ST_NEXT, ST_STOP
    } st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ten;
        logic              rd;
        logic              nostart;
        logic              last;
    } desc_t;

    function automatic logic [BYTE_W-1:0] short_addr(input logic [ADDR_W-1:0] a, input logic rd);
        return {a[6:0], rd};
    endfunction

    function automatic logic [BYTE_W-1:0] long_hdr(input logic [ADDR_W-1:0] a, input logic rd);
        return {5'b11110, a[9:8], rd};
    endfunction
endpackage

// File: rtl/aseq_cmd_gen.sv
module aseq_cmd_gen
    import i2c_aseq_pkg::*;
(
    input  st_e               st,
    input  desc_t             desc,
    output logic              is_cmd,
    output bus_op_e           op,
    output logic [BYTE_W-1:0] wbyte
);
    always_comb begin
        is_cmd = 1'b1;
        op     = OP_WRITE;
        wbyte  = '0;
        case (st)
            ST_START:               op = OP_START;
            ST_MCODE:               wbyte = MASTER_CODE;
            ST_HSRS, ST_RS, ST_RRS: op = OP_RESTART;
            ST_A1:   wbyte = desc.ten ? long_hdr(desc.addr, 1'b0) : short_addr(desc.addr, desc.rd);
            ST_A2:   wbyte = desc.addr[7:0];
            ST_A3:   wbyte = long_hdr(desc.addr, 1'b1);
            ST_STOP:                op = OP_STOP;
            default:                is_cmd = 1'b0;
        endcase
    end
endmodule

// File: rtl/aseq_watchdog.sv
module aseq_watchdog #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic hit,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm || hit || expired) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    assign expired = arm && !hit && (cnt == CW'(LIMIT - 1));

    AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (rst)
        arm |-> (cnt < CW'(LIMIT))); // R9
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
    import i2c_aseq_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        desc_valid,
    output logic        desc_ready,
    input  logic [9:0]  desc_addr,
    input  logic        desc_ten,
    input  logic        desc_rd,
    input  logic        desc_nostart,
    input  logic        desc_last,
    input  logic        desc_hs,
    output logic        cmd_valid,
    output logic [1:0]  cmd_op,
    output logic [7:0]  cmd_byte,
    input  logic        cmd_done,
    input  logic        cmd_nak,
    output logic        xfer_start,
    input  logic        xfer_done,
    input  logic        xfer_ok,
    output logic        speed_hs,
    output logic        txn_done,
    output logic [1:0]  txn_result
);
    st_e     st;
    desc_t   desc_q, desc_in;
    logic    hs_q, issued, speed_q, done_q;
    res_e    err;
    logic    is_cmd, step_hit, expired;
    bus_op_e op;
    logic [BYTE_W-1:0] wbyte;

    assign desc_in = '{addr: desc_addr, ten: desc_ten, rd: desc_rd,
                       nostart: desc_nostart, last: desc_last};

    aseq_cmd_gen u_gen (.st(st), .desc(desc_q), .is_cmd(is_cmd), .op(op), .wbyte(wbyte));

    assign cmd_valid  = is_cmd && !issued;
    assign cmd_op     = op;
    assign cmd_byte   = wbyte;
    assign xfer_start = (st == ST_DATA) && !issued;
    assign desc_ready = (st == ST_IDLE) || (st == ST_NEXT);
    assign step_hit   = issued && (is_cmd ? cmd_done : xfer_done);
    assign speed_hs   = speed_q;
    assign txn_done   = done_q;
    assign txn_result = err;

    aseq_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk(clk), .rst(rst), .arm(issued), .hit(step_hit), .expired(expired));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            desc_q  <= '0;
            hs_q    <= 1'b0;
            issued  <= 1'b0;
            speed_q <= 1'b0;
            done_q  <= 1'b0;
            err     <= RES_OK;
        end else begin
            done_q <= 1'b0;
            if (cmd_valid || xfer_start) issued <= 1'b1;
            case (st)
                ST_IDLE: if (desc_valid) begin
                    desc_q <= desc_in;
                    hs_q   <= desc_hs;
                    err    <= RES_OK;
                    st     <= ST_START;
                end
                ST_NEXT: if (desc_valid) begin
                    desc_q <= desc_in;
                    st     <= desc_nostart ? ST_DATA : ST_RS;
                end
                default: begin
                    if (step_hit) begin
                        issued <= 1'b0;
                        if ((st == ST_A1 || st == ST_A2 || st == ST_A3) && cmd_nak) begin
                            err <= RES_NAK;
                            st  <= ST_STOP;
                        end else begin
                            case (st)
                                ST_START: st <= hs_q ? ST_MCODE : ST_A1;
                                ST_MCODE: begin
                                    if (cmd_nak) begin
                                        speed_q <= 1'b1;
                                        st      <= ST_HSRS;
                                    end else begin
                                        err <= RES_NAK;
                                        st  <= ST_STOP;
                                    end
                                end
                                ST_HSRS, ST_RS: st <= ST_A1;
                                ST_A1:    st <= desc_q.ten ? ST_A2 : ST_DATA;
                                ST_A2:    st <= desc_q.rd ? ST_RRS : ST_DATA;
                                ST_RRS:   st <= ST_A3;
                                ST_A3:    st <= ST_DATA;
                                ST_DATA: begin
                                    if (!xfer_ok) begin
                                        err <= RES_DATA;
                                        st  <= ST_STOP;
                                    end else begin
                                        st <= desc_q.last ? ST_STOP : ST_NEXT;
                                    end
                                end
                                default: begin
                                    speed_q <= 1'b0;
                                    done_q  <= 1'b1;
                                    st      <= ST_IDLE;
                                end
                            endcase
                        end
                    end else if (expired) begin
                        issued <= 1'b0;
                        err    <= RES_TIMEOUT;
                        if (st == ST_STOP) begin
                            speed_q <= 1'b0;
                            done_q  <= 1'b1;
                            st      <= ST_IDLE;
                        end else begin
                            st <= ST_STOP;
                        end
                    end
                end
            endcase
        end
    end

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        txn_done |=> !txn_done); // R7
    AST_STD_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        txn_done |-> !speed_hs); // R7
    AST_HS_AFTER_NAK: assert property (@(posedge clk) disable iff (rst)
        $rose(speed_hs) |-> $past(cmd_done && cmd_nak)); // R6
    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        txn_done |-> $past(st == ST_STOP)); // R7
    AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && xfer_start)); // R10
endmodule

// File: tb/test_i2c_addr_seq.sv
module test_i2c_addr_seq;
    localparam int TMO = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst;
    logic desc_valid, desc_ready, desc_ten, desc_rd, desc_nostart, desc_last, desc_hs;
    logic [9:0] desc_addr;
    logic cmd_valid, cmd_done, cmd_nak, xfer_start, xfer_done, xfer_ok;
    logic [1:0] cmd_op, txn_result;
    logic [7:0] cmd_byte;
    logic speed_hs, txn_done;

    i2c_addr_seq #(.TIMEOUT_CYC(TMO)) i_i2c_addr_seq (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
        .desc_ten(desc_ten), .desc_rd(desc_rd), .desc_nostart(desc_nostart),
        .desc_last(desc_last), .desc_hs(desc_hs),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .cmd_done(cmd_done), .cmd_nak(cmd_nak),
        .xfer_start(xfer_start), .xfer_done(xfer_done), .xfer_ok(xfer_ok),
        .speed_hs(speed_hs), .txn_done(txn_done), .txn_result(txn_result));

    int checks = 0;
    int fails  = 0;
    int txn_cnt = 0;

    // engine / data-mover knobs
    int       eng_delay = 1;
    logic [8:0] nak_byte = 9'h100;
    bit       mc_ack = 0;
    bit       mute_start = 0;
    bit       xfer_mute = 0;
    bit       xfer_good = 1;

    // expected item: {speed, kind[2:0], byte}; kind 0..3 = cmd_op, 4 = data phase
    logic [11:0] exp_q[$];
    string       tag_q[$];
    int          res_q[$];
    string       rtag_q[$];

    function automatic logic [7:0] a7(input logic [9:0] a, input bit rd);
        return {a[6:0], rd};
    endfunction
    function automatic logic [7:0] h10(input logic [9:0] a, input bit rd);
        return {5'b11110, a[9:8], rd};
    endfunction

    task automatic expect_item(input int kind, input logic [7:0] b, input bit spd, input string tag);
        exp_q.push_back({spd, kind[2:0], b});
        tag_q.push_back(tag);
    endtask

    task automatic expect_result(input int r, input string tag);
        res_q.push_back(r);
        rtag_q.push_back(tag);
    endtask

    task automatic send_desc(input logic [9:0] a, input bit ten, input bit rd,
                             input bit ns, input bit last, input bit hs);
        @(negedge clk);
        while (!desc_ready) @(negedge clk);
        desc_valid = 1'b1; desc_addr = a; desc_ten = ten; desc_rd = rd;
        desc_nostart = ns; desc_last = last; desc_hs = hs;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic wait_txn;
        int start;
        start = txn_cnt;
        while (txn_cnt == start) @(negedge clk);
    endtask

    task automatic check_item(input int kind, input logic [7:0] b);
        logic [11:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R10 unexpected step: act kind=%0d byte=%02h exp none", kind, b);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (kind != int'(e[10:8]) || (kind == 3 && b != e[7:0]) || speed_hs != e[11]) begin
                fails++;
                $display("FAIL %s step: act spd=%0b kind=%0d byte=%02h exp spd=%0b kind=%0d byte=%02h",
                         t, speed_hs, kind, b, e[11], e[10:8], e[7:0]);
            end
        end
    endtask

    // bit-engine model and command monitor
    initial begin
        cmd_done = 1'b0; cmd_nak = 1'b0;
        forever begin
            @(negedge clk);
            cmd_done = 1'b0; cmd_nak = 1'b0;
            if (!rst && cmd_valid) begin
                logic [1:0] op_s;
                logic [7:0] b_s;
                op_s = cmd_op; b_s = cmd_byte;
                check_item(int'(op_s), b_s);
                if (!(mute_start && op_s == 2'd0)) begin
                    repeat (eng_delay) @(negedge clk);
                    cmd_done = 1'b1;
                    if (op_s == 2'd3)
                        cmd_nak = (b_s == 8'h08) ? !mc_ack : (!nak_byte[8] && b_s == nak_byte[7:0]);
                end
            end
        end
    end

    // data-mover model
    initial begin
        xfer_done = 1'b0; xfer_ok = 1'b0;
        forever begin
            @(negedge clk);
            xfer_done = 1'b0; xfer_ok = 1'b0;
            if (!rst && xfer_start) begin
                check_item(4, 8'h00);
                if (!xfer_mute) begin
                    repeat (2) @(negedge clk);
                    xfer_done = 1'b1;
                    xfer_ok = xfer_good;
                end
            end
        end
    end

    // result monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txn_done) begin
                checks++;
                if (res_q.size() == 0) begin
                    fails++;
                    $display("FAIL R7 unexpected done: act result=%0d exp none", txn_result);
                end else begin
                    int r;
                    string t;
                    r = res_q.pop_front();
                    t = rtag_q.pop_front();
                    if (int'(txn_result) != r) begin
                        fails++;
                        $display("FAIL %s result: act %0d exp %0d", t, txn_result, r);
                    end
                end
                checks++;
                if (speed_hs !== 1'b0) begin
                    fails++;
                    $display("FAIL R7 speed at done: act %0b exp 0", speed_hs);
                end
                checks++;
                if (exp_q.size() != 0) begin
                    fails++;
                    $display("FAIL R5 missing steps at done: act %0d left exp 0", exp_q.size());
                    exp_q.delete(); tag_q.delete();
                end
                txn_cnt++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: act hung exp finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        desc_valid = 1'b0; desc_addr = '0; desc_ten = 0; desc_rd = 0;
        desc_nostart = 0; desc_last = 0; desc_hs = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        checks++;
        if (desc_ready !== 1'b1 || cmd_valid !== 1'b0 || xfer_start !== 1'b0 ||
            txn_done !== 1'b0 || speed_hs !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset: act rdy=%0b cv=%0b xs=%0b dn=%0b hs=%0b exp 1 0 0 0 0",
                     desc_ready, cmd_valid, xfer_start, txn_done, speed_hs);
        end

        // R1 7-bit write
        expect_item(0, 0, 0, "R4"); expect_item(3, a7(10'h050, 0), 0, "R1");
        expect_item(4, 0, 0, "R8"); expect_item(2, 0, 0, "R7");
        expect_result(0, "R1");
        send_desc(10'h050, 0, 0, 0, 1, 0); wait_txn();

        // R1 7-bit read
        expect_item(0, 0, 0, "R4"); expect_item(3, a7(10'h03B, 1), 0, "R1");
        expect_item(4, 0, 0, "R8"); expect_item(2, 0, 0, "R7");
        expect_result(0, "R1");
        send_desc(10'h03B, 0, 1, 0, 1, 0); wait_txn();

        // R4 no-start ignored on the first message
        expect_item(0, 0, 0, "R4"); expect_item(3, a7(10'h011, 0), 0, "R4");
        expect_item(4, 0, 0, "R8"); expect_item(2, 0, 0, "R7");
        expect_result(0, "R4");
        send_desc(10'h011, 0, 0, 1, 1, 0); wait_txn();

        // R2 10-bit write
        expect_item(0, 0, 0, "R4"); expect_item(3, h10(10'h2A5, 0), 0, "R2");
        expect_item(3, 8'hA5, 0, "R2"); expect_item(4, 0, 0, "R8"); expect_item(2, 0, 0, "R7");
        expect_result(0, "R2");
        send_desc(10'h2A5, 1, 0, 0, 1, 0); wait_txn();

        // R3 10-bit read
        expect_item(0, 0, 0, "R4"); expect_item(3, h10(10'h1C3, 0), 0, "R2");
        expect_item(3, 8'hC3, 0, "R2"); expect_item(1, 0, 0, "R3");
        expect_item(3, h10(10'h1C3, 1), 0, "R3");
        expect_item(4, 0, 0, "R8"); expect_item(2, 0, 0, "R7");
        expect_result(0, "R3");
        send_desc(10'h1C3, 1, 1, 0, 1, 0); wait_txn();

        // R4 multi-message with restart and no-start continuation
        expect_item(0, 0, 0, "R4"); expect_item(3, a7(10'h021, 0), 0, "R1");
        expect_item(4, 0, 0, "R8");
        expect_item(1, 0, 0, "R4"); expect_item(3, a7(10'h021, 1), 0, "R4");
        expect_item(4, 0, 0, "R8");
        expect_item(4, 0, 0, "R4"); expect_item(2, 0, 0, "R7");
        expect_result(0, "R4");
        send_desc(10'h021, 0, 0, 0, 0, 0);
        send_desc(10'h021, 0, 1, 0, 0, 0);
        send_desc(10'h000, 0, 0, 1, 1, 0);
        wait_txn();

        // R5 7-bit address NAK
        nak_byte = {1'b0, a7(10'h050, 0)};
        expect_item(0, 0, 0, "R4"); expect_item(3, a7(10'h050, 0), 0, "R5");
        expect_item(2, 0, 0, "R5");
        expect_result(1, "R5");
        send_desc(10'h050, 0, 0, 0, 0, 0); wait_txn();

        // R5 NAK on second 10-bit byte
        nak_byte = 9'h0A5;
        expect_item(0, 0, 0, "R4"); expect_item(3, h10(10'h2A5, 0), 0, "R2");
        expect_item(3, 8'hA5, 0, "R5"); expect_item(2, 0, 0, "R5");
        expect_result(1, "R5");
        send_desc(10'h2A5, 1, 0, 0, 1, 0); wait_txn();
        nak_byte = 9'h100;

        // R6 high-speed entry, 7-bit read
        expect_item(0, 0, 0, "R6"); expect_item(3, 8'h08, 0, "R6");
        expect_item(1, 0, 1, "R6"); expect_item(3, a7(10'h010, 1), 1, "R6");
        expect_item(4, 0, 1, "R8"); expect_item(2, 0, 1, "R7");
        expect_result(0, "R6");
        send_desc(10'h010, 0, 1, 0, 1, 1); wait_txn();

        // R6 master code ACKed is an error
        mc_ack = 1;
        expect_item(0, 0, 0, "R6"); expect_item(3, 8'h08, 0, "R6");
        expect_item(2, 0, 0, "R6");
        expect_result(1, "R6");
        send_desc(10'h010, 0, 0, 0, 1, 1); wait_txn();
        mc_ack = 0;

        // R6 + R5 address NAK in high speed, speed drops after STOP
        nak_byte = {1'b0, a7(10'h033, 0)};
        expect_item(0, 0, 0, "R6"); expect_item(3, 8'h08, 0, "R6");
        expect_item(1, 0, 1, "R6"); expect_item(3, a7(10'h033, 0), 1, "R5");
        expect_item(2, 0, 1, "R7");
        expect_result(1, "R5");
        send_desc(10'h033, 0, 0, 0, 1, 1); wait_txn();
        nak_byte = 9'h100;

        // R8 data failure
        xfer_good = 0;
        expect_item(0, 0, 0, "R4"); expect_item(3, a7(10'h044, 0), 0, "R1");
        expect_item(4, 0, 0, "R8"); expect_item(2, 0, 0, "R8");
        expect_result(2, "R8");
        send_desc(10'h044, 0, 0, 0, 0, 0); wait_txn();
        xfer_good = 1;

        // R9 data phase never finishes
        xfer_mute = 1;
        expect_item(0, 0, 0, "R4"); expect_item(3, a7(10'h044, 1), 0, "R1");
        expect_item(4, 0, 0, "R9"); expect_item(2, 0, 0, "R9");
        expect_result(3, "R9");
        send_desc(10'h044, 0, 1, 0, 1, 0); wait_txn();
        xfer_mute = 0;

        // R9 START never answered
        mute_start = 1;
        expect_item(0, 0, 0, "R9"); expect_item(2, 0, 0, "R9");
        expect_result(3, "R9");
        send_desc(10'h044, 0, 0, 0, 1, 0); wait_txn();
        mute_start = 0;

        // R9 completion in the final watchdog cycle is accepted
        eng_delay = TMO;
        expect_item(0, 0, 0, "R9"); expect_item(3, h10(10'h3F0, 0), 0, "R9");
        expect_item(3, 8'hF0, 0, "R9"); expect_item(4, 0, 0, "R8"); expect_item(2, 0, 0, "R9");
        expect_result(0, "R9");
        send_desc(10'h3F0, 1, 0, 0, 1, 0); wait_txn();
        eng_delay = 1;

        repeat (5) @(negedge clk);
        // R10 no stray commands while idle
        checks++;
        if (exp_q.size() != 0 || res_q.size() != 0) begin
            fails++;
            $display("FAIL R10 leftovers: act %0d/%0d exp 0/0", exp_q.size(), res_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule